// File: doc/BRIEF.md
# Double-Buffered Bulk IN Endpoint Transmit FIFO

This block holds outgoing data for one bulk IN endpoint in two packet slots. The processor side fills one slot a byte at a time, then pulses a packet-enable strobe. The strobe closes that slot, records how many bytes it holds, hands it to the bus side and moves processor writes to the other slot. The bus side sees the oldest enabled slot as the current packet, with its length. It reads the bytes in order and pulses a done strobe when the packet has gone out, which returns the slot for writing.

A slot changes hands only through the strobe. Data never flows from one slot into the other. A slot holds at most one maximum-size packet. Surplus bytes are discarded and raise a sticky overwrite flag. When both slots are waiting for the bus, a full status is shown: further writes are discarded with the overwrite flag, and the strobe does nothing. A clear input discards all pending data, for example after the cable is unplugged. The clear is refused while the bus side is part-way through reading a packet.

Top module: `dbf_in_fifo`

## Requirements
- R1: After reset, `usb_pkt_valid`, `buf_full` and `ovw_err` are 0 and `cpu_wr_count` is 0.
- R2: Each accepted `cpu_wr_en` cycle stores `cpu_wr_data` in the current write slot and raises `cpu_wr_count` by one on the following cycle.
- R3: A write while `cpu_wr_count` equals `MAX_PKT` is discarded. `cpu_wr_count` stays at `MAX_PKT` and `ovw_err` becomes 1 and stays 1 until an accepted clear.
- R4: An accepted `cpu_pkt_en` enqueues the write slot with a length equal to the bytes written into it. `cpu_wr_count` returns to 0 and writes continue in the other slot.
- R5: The bus side receives a packet's bytes on `usb_rd_data` in the order they were written. Each `usb_rd_en` cycle advances by one byte, up to `usb_pkt_len`.
- R6: Packets are presented on `usb_pkt_valid`/`usb_pkt_len` in the order their packet-enable strobes were accepted.
- R7: While both slots are enqueued, `buf_full` is 1, `cpu_pkt_en` has no effect and writes are discarded and set `ovw_err`.
- R8: `usb_done` while `usb_pkt_valid` is 1 releases the current packet. The next enqueued packet, if any, is presented on the following cycle, and `buf_full` falls.
- R9: `fifo_clr`, when no packet is part-way read, discards both slots and the partial write slot. It clears `ovw_err` and `cpu_wr_count`.
- R10: `fifo_clr` is ignored while at least one byte of the current packet has been read and `usb_done` has not yet been given. The packet, its length and its read position are kept.
- R11: `cpu_pkt_en` with no bytes written enqueues a packet of length 0.
- R12: A write accepted in the same cycle as an accepted `cpu_pkt_en` belongs to the packet being enqueued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Write one byte into the current write slot |
| cpu_wr_data | input | DATA_W | Byte to write |
| cpu_pkt_en | input | 1 | Packet-enable strobe |
| fifo_clr | input | 1 | Discard all pending data |
| cpu_wr_count | output | CNT_W | Bytes in the current write slot |
| buf_full | output | 1 | Both slots waiting for the bus side |
| ovw_err | output | 1 | Sticky overwrite error |
| usb_pkt_valid | output | 1 | A packet is presented to the bus side |
| usb_pkt_len | output | CNT_W | Length of the presented packet |
| usb_rd_en | input | 1 | Advance to the next byte |
| usb_rd_data | output | DATA_W | Byte at the current read position |
| usb_done | input | 1 | Presented packet has been sent |

## Verification
The hardest state to reach is a clear that arrives after the bus side has begun a packet but before done. Random stimulus always drains whole packets, so it never lands there. A directed case enqueues a packet, reads one byte, pulses the clear, and then checks that the length is unchanged and the remaining bytes continue from the second one. The full condition comes from random bursts of up to 70 bytes per slot with draining skipped on about half of the rounds. These bursts also drive writes past the size limit and into a full FIFO.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef enum logic {
    SLOT_A = 1'b0,
    SLOT_B = 1'b1
  } slot_e;

  function automatic slot_e other_slot(input slot_e s);
    return (s == SLOT_A) ? SLOT_B : SLOT_A;
  endfunction

endpackage

// File: rtl/dbf_rst_sync.sv
module dbf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/dbf_buf.sv
module dbf_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/dbf_ctrl.sv
module dbf_ctrl
  import dbf_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int CNT_W   = 7,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              pkt_en,
  input  logic              clr,
  input  logic              rd_en,
  input  logic              done,
  output slot_e             wr_slot,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_ok,
  output slot_e             rd_slot,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  wr_count,
  output logic              full,
  output logic              err,
  output logic              pkt_valid,
  output logic [CNT_W-1:0]  pkt_len
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_PKT);

  logic [1:0]       queued_q, queued_d;
  logic [CNT_W-1:0] len_q [2];
  logic [CNT_W-1:0] len_d [2];
  slot_e            wr_sel_q, wr_sel_d;
  slot_e            head_q, head_d;
  logic [CNT_W-1:0] wr_cnt_q, wr_cnt_d;
  logic [CNT_W-1:0] rd_ptr_q, rd_ptr_d;
  logic             err_q, err_d;

  logic busy, clr_ok, wr_free, wr_drop, trig_ok, rd_step, done_ok;

  // Admission decisions for the current cycle
  always_comb begin
    busy    = queued_q[head_q] && (rd_ptr_q != '0);
    clr_ok  = clr && !busy;
    wr_free = !queued_q[wr_sel_q];
    wr_ok   = wr_en && wr_free && (wr_cnt_q < MAX_CNT) && !clr_ok;
    wr_drop = wr_en && !wr_ok && !clr_ok;
    trig_ok = pkt_en && wr_free && !clr_ok;
    rd_step = rd_en && queued_q[head_q] && (rd_ptr_q < len_q[head_q]) && !clr_ok;
    done_ok = done && queued_q[head_q] && !clr_ok;
  end

  // Next-state logic
  always_comb begin
    queued_d = queued_q;
    len_d[0] = len_q[0];
    len_d[1] = len_q[1];
    wr_sel_d = wr_sel_q;
    head_d   = head_q;
    wr_cnt_d = wr_cnt_q;
    rd_ptr_d = rd_ptr_q;
    err_d    = err_q;
    if (clr_ok) begin
      queued_d = '0;
      wr_sel_d = SLOT_A;
      head_d   = SLOT_A;
      wr_cnt_d = '0;
      rd_ptr_d = '0;
      err_d    = 1'b0;
    end else begin
      if (wr_ok) begin
        wr_cnt_d = wr_cnt_q + 1'b1;
      end
      if (wr_drop) begin
        err_d = 1'b1;
      end
      if (trig_ok) begin
        queued_d[wr_sel_q] = 1'b1;
        len_d[wr_sel_q]    = wr_cnt_q + CNT_W'(wr_ok);
        wr_cnt_d           = '0;
        wr_sel_d           = other_slot(wr_sel_q);
      end
      if (done_ok) begin
        queued_d[head_q] = 1'b0;
        head_d           = other_slot(head_q);
        rd_ptr_d         = '0;
      end else if (rd_step) begin
        rd_ptr_d = rd_ptr_q + 1'b1;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      queued_q <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
      wr_sel_q <= SLOT_A;
      head_q   <= SLOT_A;
      wr_cnt_q <= '0;
      rd_ptr_q <= '0;
      err_q    <= 1'b0;
    end else begin
      queued_q <= queued_d;
      len_q[0] <= len_d[0];
      len_q[1] <= len_d[1];
      wr_sel_q <= wr_sel_d;
      head_q   <= head_d;
      wr_cnt_q <= wr_cnt_d;
      rd_ptr_q <= rd_ptr_d;
      err_q    <= err_d;
    end
  end

  assign wr_slot   = wr_sel_q;
  assign wr_addr   = wr_cnt_q[ADDR_W-1:0];
  assign rd_slot   = head_q;
  assign rd_addr   = rd_ptr_q[ADDR_W-1:0];
  assign wr_count  = wr_cnt_q;
  assign full      = &queued_q;
  assign err       = err_q;
  assign pkt_valid = queued_q[head_q];
  assign pkt_len   = len_q[head_q];

  // R3: write count never passes the packet limit
  a_r3_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count <= MAX_CNT);

  // R3: a write at the limit raises the overwrite flag
  a_r3_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_count == MAX_CNT && !clr) |=> err);

  // R5: the read position stays inside the presented packet
  a_r5_rd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (rd_ptr_q <= pkt_len));

  // R4: a strobe on an empty FIFO presents the written length
  a_r4_trig_presents: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_en && !wr_en && !pkt_valid && !clr) |=> (pkt_valid && pkt_len == $past(wr_count)));

  // R7: a strobe while full leaves the FIFO full
  a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pkt_en && !done && !clr) |=> full);

  // R8: done with a single packet pending leaves nothing presented
  a_r8_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pkt_valid && !full && !pkt_en && !clr) |=> !pkt_valid);

  // R10: a clear during a part-read packet keeps it presented
  a_r10_busy_clear_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clr && !done) |=> (pkt_valid && $stable(pkt_len)));

endmodule

// File: rtl/dbf_in_fifo.sv
module dbf_in_fifo
  import dbf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_PKT = 64,
  localparam int CNT_W  = $clog2(MAX_PKT + 1),
  localparam int ADDR_W = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              cpu_pkt_en,
  input  logic              fifo_clr,
  output logic [CNT_W-1:0]  cpu_wr_count,
  output logic              buf_full,
  output logic              ovw_err,
  output logic              usb_pkt_valid,
  output logic [CNT_W-1:0]  usb_pkt_len,
  input  logic              usb_rd_en,
  output logic [DATA_W-1:0] usb_rd_data,
  input  logic              usb_done
);

  localparam int NUM_SLOTS = 2;

  logic              rst_n_sync;
  slot_e             wr_slot;
  slot_e             rd_slot;
  logic              wr_ok;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] slot_rdata [NUM_SLOTS];

  dbf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dbf_ctrl #(
    .MAX_PKT (MAX_PKT),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_en     (cpu_wr_en),
    .pkt_en    (cpu_pkt_en),
    .clr       (fifo_clr),
    .rd_en     (usb_rd_en),
    .done      (usb_done),
    .wr_slot   (wr_slot),
    .wr_addr   (wr_addr),
    .wr_ok     (wr_ok),
    .rd_slot   (rd_slot),
    .rd_addr   (rd_addr),
    .wr_count  (cpu_wr_count),
    .full      (buf_full),
    .err       (ovw_err),
    .pkt_valid (usb_pkt_valid),
    .pkt_len   (usb_pkt_len)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    dbf_buf #(
      .DATA_W (DATA_W),
      .DEPTH  (MAX_PKT),
      .ADDR_W (ADDR_W)
    ) u_buf (
      .clk   (clk),
      .we    (wr_ok && (wr_slot == slot_e'(g))),
      .waddr (wr_addr),
      .wdata (cpu_wr_data),
      .raddr (rd_addr),
      .rdata (slot_rdata[g])
    );
  end

  assign usb_rd_data = slot_rdata[rd_slot];

endmodule

// File: tb/dbf_in_fifo_bench.sv
`timescale 1ns/1ps
module dbf_in_fifo_bench;

  localparam int DATA_W  = 8;
  localparam int MAX_PKT = 64;
  localparam int CNT_W   = $clog2(MAX_PKT + 1);

  logic              clk;
  logic              rst_n;
  logic              cpu_wr_en;
  logic [DATA_W-1:0] cpu_wr_data;
  logic              cpu_pkt_en;
  logic              fifo_clr;
  logic [CNT_W-1:0]  cpu_wr_count;
  logic              buf_full;
  logic              ovw_err;
  logic              usb_pkt_valid;
  logic [CNT_W-1:0]  usb_pkt_len;
  logic              usb_rd_en;
  logic [DATA_W-1:0] usb_rd_data;
  logic              usb_done;

  dbf_in_fifo #(.DATA_W(DATA_W), .MAX_PKT(MAX_PKT)) u_dbf_in_fifo (
    .clk (clk), .rst_n (rst_n),
    .cpu_wr_en (cpu_wr_en), .cpu_wr_data (cpu_wr_data),
    .cpu_pkt_en (cpu_pkt_en), .fifo_clr (fifo_clr),
    .cpu_wr_count (cpu_wr_count), .buf_full (buf_full), .ovw_err (ovw_err),
    .usb_pkt_valid (usb_pkt_valid), .usb_pkt_len (usb_pkt_len),
    .usb_rd_en (usb_rd_en), .usb_rd_data (usb_rd_data), .usb_done (usb_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks;
  int failures;
  bit finished;

  // Reference model state
  int ref_data [2][MAX_PKT];
  int ref_len  [2];
  int ref_head;
  int ref_n;
  int ref_rd;
  int cur [MAX_PKT];
  int cur_n;
  bit ref_err;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len();
    return (ref_n > 0) ? ref_len[ref_head] : 0;
  endfunction

  function automatic int exp_byte();
    return ref_data[ref_head][ref_rd];
  endfunction

  task automatic check_status(input string req);
    chk(int'(cpu_wr_count) == cur_n, req, int'(cpu_wr_count), cur_n);
    chk(buf_full == (ref_n == 2), req, int'(buf_full), int'(ref_n == 2));
    chk(ovw_err == ref_err, req, int'(ovw_err), int'(ref_err));
    chk(usb_pkt_valid == (ref_n > 0), req, int'(usb_pkt_valid), int'(ref_n > 0));
    if (ref_n > 0)
      chk(int'(usb_pkt_len) == exp_len(), req, int'(usb_pkt_len), exp_len());
  endtask

  function automatic void model_write(input int d);
    if (ref_n == 2 || cur_n == MAX_PKT) ref_err = 1'b1;
    else begin
      cur[cur_n] = d;
      cur_n++;
    end
  endfunction

  function automatic void model_trig();
    int slot;
    if (ref_n < 2) begin
      slot = (ref_head + ref_n) % 2;
      for (int i = 0; i < cur_n; i++) ref_data[slot][i] = cur[i];
      ref_len[slot] = cur_n;
      ref_n++;
      cur_n = 0;
    end
  endfunction

  // All tasks start at a falling edge and end at a falling edge
  task automatic cpu_write(input int d);
    cpu_wr_en = 1'b1;
    cpu_wr_data = DATA_W'(d);
    @(negedge clk);
    cpu_wr_en = 1'b0;
    model_write(d);
  endtask

  task automatic cpu_trig();
    cpu_pkt_en = 1'b1;
    @(negedge clk);
    cpu_pkt_en = 1'b0;
    model_trig();
  endtask

  task automatic write_and_trig(input int d);
    cpu_wr_en = 1'b1;
    cpu_wr_data = DATA_W'(d);
    cpu_pkt_en = 1'b1;
    @(negedge clk);
    cpu_wr_en = 1'b0;
    cpu_pkt_en = 1'b0;
    model_write(d);
    model_trig();
  endtask

  task automatic clear(input bit model_busy);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    if (!model_busy) begin
      ref_n = 0; ref_head = 0; ref_rd = 0; cur_n = 0; ref_err = 1'b0;
    end
  endtask

  task automatic read_bytes(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(int'(usb_rd_data) == exp_byte(), req, int'(usb_rd_data), exp_byte());
      usb_rd_en = 1'b1;
      @(negedge clk);
      usb_rd_en = 1'b0;
      ref_rd++;
    end
  endtask

  task automatic finish_pkt();
    usb_done = 1'b1;
    @(negedge clk);
    usb_done = 1'b0;
    if (ref_n > 0) begin
      ref_n--;
      ref_head = (ref_head + 1) % 2;
      ref_rd = 0;
    end
  endtask

  task automatic drain(input string req);
    if (ref_n > 0) begin
      read_bytes(ref_len[ref_head] - ref_rd, req);
      finish_pkt();
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int n;
    checks = 0; failures = 0; finished = 1'b0;
    ref_n = 0; ref_head = 0; ref_rd = 0; cur_n = 0; ref_err = 1'b0;
    void'($urandom(32'h1f2e3d4c));
    rst_n = 1'b0;
    cpu_wr_en = 1'b0; cpu_wr_data = '0; cpu_pkt_en = 1'b0;
    fifo_clr = 1'b0; usb_rd_en = 1'b0; usb_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_status("R1");

    // R2, R4, R5: simple packet
    for (int i = 0; i < 5; i++) cpu_write(8'h10 + i);
    check_status("R2");
    cpu_trig();
    check_status("R4");
    drain("R5");
    check_status("R8");

    // R11: zero-length packet
    cpu_trig();
    check_status("R11");
    chk(int'(usb_pkt_len) == 0, "R11", int'(usb_pkt_len), 0);
    finish_pkt();

    // R12: write together with the strobe
    cpu_write(8'hA1);
    write_and_trig(8'hA2);
    check_status("R12");
    drain("R12");

    // R3: overfill a slot
    for (int i = 0; i < MAX_PKT + 3; i++) cpu_write(i * 3);
    check_status("R3");
    chk(int'(cpu_wr_count) == MAX_PKT, "R3", int'(cpu_wr_count), MAX_PKT);
    cpu_trig();
    drain("R3");
    clear(1'b0);
    check_status("R9");

    // R6, R7: fill both slots, then try more
    for (int i = 0; i < 4; i++) cpu_write(8'h40 + i);
    cpu_trig();
    for (int i = 0; i < 7; i++) cpu_write(8'h80 + i);
    cpu_trig();
    check_status("R7");
    cpu_write(8'hEE);
    cpu_trig();
    check_status("R7");
    drain("R6");
    check_status("R8");
    drain("R6");
    check_status("R6");

    // R9: clear discards queued, partial and error
    for (int i = 0; i < 5; i++) cpu_write(i);
    cpu_trig();
    cpu_write(9);
    for (int i = 0; i < 3; i++) cpu_write(i);
    cpu_trig(); cpu_trig(); cpu_write(1);
    clear(1'b0);
    check_status("R9");

    // R10: clear during a part-read packet
    for (int i = 0; i < 6; i++) cpu_write(8'hC0 + i);
    cpu_trig();
    read_bytes(1, "R10");
    clear(1'b1);
    check_status("R10");
    drain("R10");
    check_status("R10");

    // Random mix
    for (int it = 0; it < 120; it++) begin
      n = $urandom_range(0, 70);
      for (int i = 0; i < n; i++) cpu_write($urandom_range(0, 255));
      check_status("R2");
      if ($urandom_range(0, 3) != 0) cpu_trig();
      check_status("R4");
      if ($urandom_range(0, 1) == 1) drain("R5");
      check_status("R6");
      if ($urandom_range(0, 9) == 0) begin
        clear(1'b0);
        check_status("R9");
      end
    end
    drain("R5");
    drain("R5");
    check_status("R8");

    summary();
  end

endmodule